// File: doc/BRIEF.md
# UART register and interrupt latch unit

This block is the bus-facing register file of a high-speed UART with a fixed 8N1 frame. A simple 32-bit read/write bus reaches five word registers:

- the data port;
- the FIFO fill report;
- the interrupt cause register;
- the control word;
- the bit-rate divider.

The serializer, the deserializer and both FIFOs sit outside the block. They connect through a pop strobe, a push strobe with its byte, fill counts and a vector of event inputs.

A read of the data port returns the next received byte in one word, together with flags that say the FIFO was empty, the byte had a framing error, or it marked a break. A write to the data port hands the byte to the transmit FIFO. Hardware events latch into the cause register, and software clears them by writing ones. The two receive-request causes are not latched: they follow the receive FIFO's trigger and timeout levels.

One interrupt output combines the causes with three enable bits of the control word, one each for transmit, receive and error. Control bit 8 drives the transmit line into the break condition.

Top module: `hsu_regfront`

## Requirements
- R1: Registers are decoded from byte-address bits [4:2], and address bits [1:0] are ignored. The word offsets are 0x00 data, 0x04 level, 0x08 status, 0x0C control and 0x10 rate. A read of the level word returns the transmit fill count in bits 15:8 and the receive fill count in bits 7:0, with every other bit zero.
- R2: A read of the data word with a nonzero receive fill returns the byte in bits 7:0, the framing-error flag in bit 9 and the break flag in bit 10, with bit 8 clear. It also asserts `rxf_pop` for that one access cycle. With a fill of zero, the read returns exactly 0x100 and `rxf_pop` stays low.
- R3: A write to the data word asserts `txf_push` during the access and presents `bus_wdata[7:0]` on `txf_byte`. No other access raises `txf_push`.
- R4: The status bits 0 (transmit request), 3 (framing error), 4 (break), 5 (overrun) and 6 (transmit set) latch on a one-cycle pulse of the matching `evt` bit. They remain set until software clears them.
- R5: Writing the status word clears each latched bit whose write-data bit is 1. Bits written 0 keep their value.
- R6: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Status bits 1 (receive trigger) and 2 (receive timeout) always equal `evt[1]` and `evt[2]`. A write of ones to them has no effect.
- R8: `irq` is driven high in three cases: status bit 0 with control bit 5; status bit 1 or 2 with control bit 6; any of status bits 3 to 5 with control bit 7. In every other state `irq` is low.
- R9: The control word (22 bits) and the rate word (8 bits) read back as written and drive `cfg_ctrl` and `cfg_rate`. `tx_break` equals control bit 8.
- R10: After reset the status, control and `irq` are zero and the rate is 0xFF. Reads of word offsets 0x14 to 0x1C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rxf_data | input | 8 | Byte at the head of the receive FIFO |
| rxf_frame_err | input | 1 | Framing error on the head byte |
| rxf_break | input | 1 | Head entry is a break |
| rxf_level | input | 8 | Receive FIFO fill |
| rxf_pop | output | 1 | Advance the receive FIFO |
| txf_level | input | 8 | Transmit FIFO fill |
| txf_push | output | 1 | Write a byte into the transmit FIFO |
| txf_byte | output | 8 | Byte to push |
| evt | input | 7 | Event inputs; bits 1 and 2 are levels, the rest are pulses |
| cfg_ctrl | output | 22 | Control word |
| cfg_rate | output | 8 | Rate divider |
| tx_break | output | 1 | Force the transmit line low |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt output is swept over every one of the 128 cause combinations under each of the 8 enable patterns. This shows whether each cause group is paired with the right enable bit.

The data read is swept over all 256 byte values with all four flag combinations, and it is also tried on an empty FIFO. This separates flag placement and data masking from pop gating.

Status clearing is tried three ways: with zero writes, with single-bit writes, and with a write that collides with an event pulse. These tell write-one-to-clear apart from a plain register write, and they show which side wins the collision. Level sweeps and writes to the two level-following bits confirm those bits are not latched.

// File: rtl/hsu_pkg.sv
package hsu_pkg;
   // word indices of the register map (byte offset / 4)
   localparam int WIDX_DATA = 0;
   localparam int WIDX_LVL  = 1;
   localparam int WIDX_STAT = 2;
   localparam int WIDX_CTRL = 3;
   localparam int WIDX_RATE = 4;

   localparam int NCAUSE = 7;

   // status bit positions
   localparam int ST_TXREQ  = 0;
   localparam int ST_RXTRIG = 1;
   localparam int ST_RXTMO  = 2;
   localparam int ST_FRAME  = 3;
   localparam int ST_BRK    = 4;
   localparam int ST_OVR    = 5;
   localparam int ST_TXSET  = 6;

   // which causes are latched (1) or follow their input level (0)
   localparam logic [NCAUSE-1:0] CAUSE_STICKY = 7'b111_1001;

   // control bit positions
   localparam int CB_TXEN  = 5;
   localparam int CB_RXEN  = 6;
   localparam int CB_ERREN = 7;
   localparam int CB_BRK   = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_LVL,
      SEL_STAT,
      SEL_CTRL,
      SEL_RATE
   } reg_sel_e;
endpackage

// File: rtl/hsu_addr_dec.sv
module hsu_addr_dec
   import hsu_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic             unused_lsb;

   assign widx       = addr[ADDR_W-1:2];
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      sel = SEL_NONE;
      if (widx == IDX_W'(WIDX_DATA))      sel = SEL_DATA;
      else if (widx == IDX_W'(WIDX_LVL))  sel = SEL_LVL;
      else if (widx == IDX_W'(WIDX_STAT)) sel = SEL_STAT;
      else if (widx == IDX_W'(WIDX_CTRL)) sel = SEL_CTRL;
      else if (widx == IDX_W'(WIDX_RATE)) sel = SEL_RATE;
   end
endmodule

// File: rtl/hsu_stat_latch.sv
module hsu_stat_latch #(
   parameter int           N      = 7,
   parameter logic [N-1:0] STICKY = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] st
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (STICKY[i]) begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr[i]) | evt[i];   // set beats clear
         end
         assign st[i] = q;
      end else begin : g_level
         logic unused_clr;
         assign unused_clr = clr[i];
         assign st[i]      = evt[i];
      end
   end
endmodule

// File: rtl/hsu_cfg_regs.sv
module hsu_cfg_regs #(
   parameter int CTRL_W   = 22,
   parameter int RATE_W   = 8,
   parameter int RATE_RST = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_rate,
   input  logic [31:0]       wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [RATE_W-1:0] rate_q
);
   localparam int USE_W = (CTRL_W > RATE_W) ? CTRL_W : RATE_W;

   if (USE_W < 32) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata[31:USE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rate_q <= RATE_W'(RATE_RST);
      else if (wr_rate) rate_q <= wdata[RATE_W-1:0];
   end
endmodule

// File: rtl/hsu_regfront.sv
module hsu_regfront
   import hsu_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int LVL_W    = 8,
   parameter int CTRL_W   = 22,
   parameter int RATE_W   = 8,
   parameter int RATE_RST = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [7:0]        rxf_data,
   input  logic              rxf_frame_err,
   input  logic              rxf_break,
   input  logic [LVL_W-1:0]  rxf_level,
   output logic              rxf_pop,
   input  logic [LVL_W-1:0]  txf_level,
   output logic              txf_push,
   output logic [7:0]        txf_byte,
   input  logic [NCAUSE-1:0] evt,
   output logic [CTRL_W-1:0] cfg_ctrl,
   output logic [RATE_W-1:0] cfg_rate,
   output logic              tx_break,
   output logic              irq
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("hsu_regfront: ADDR_W must cover five word registers");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("hsu_regfront: LVL_W must be 1..8");
   end
   if (CTRL_W < CB_BRK + 1 || CTRL_W > 32) begin : g_bad_ctrl
      $error("hsu_regfront: CTRL_W must hold the break bit");
   end
   if (RATE_W < 1 || RATE_W > 32) begin : g_bad_rate
      $error("hsu_regfront: RATE_W out of range");
   end

   reg_sel_e          sel;
   logic              acc_rd, acc_wr;
   logic              stat_wr, ctrl_wr, rate_wr;
   logic [NCAUSE-1:0] st_q;
   logic [NCAUSE-1:0] st_clr;
   logic              rx_empty;
   logic [31:0]       data_word;

   hsu_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign acc_rd  = bus_sel & ~bus_wr;
   assign acc_wr  = bus_sel &  bus_wr;
   assign stat_wr = acc_wr & (sel == SEL_STAT);
   assign ctrl_wr = acc_wr & (sel == SEL_CTRL);
   assign rate_wr = acc_wr & (sel == SEL_RATE);
   assign st_clr  = stat_wr ? bus_wdata[NCAUSE-1:0] : '0;

   hsu_stat_latch #(.N(NCAUSE), .STICKY(CAUSE_STICKY)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .clr   (st_clr),
      .st    (st_q)
   );

   hsu_cfg_regs #(.CTRL_W(CTRL_W), .RATE_W(RATE_W), .RATE_RST(RATE_RST)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (ctrl_wr),
      .wr_rate (rate_wr),
      .wdata   (bus_wdata),
      .ctrl_q  (cfg_ctrl),
      .rate_q  (cfg_rate)
   );

   // receive and transmit FIFO strobes
   assign rx_empty = (rxf_level == '0);
   assign rxf_pop  = acc_rd & (sel == SEL_DATA) & ~rx_empty;
   assign txf_push = acc_wr & (sel == SEL_DATA);
   assign txf_byte = bus_wdata[7:0];
   assign tx_break = cfg_ctrl[CB_BRK];

   always_comb begin
      data_word = 32'h100;
      if (!rx_empty) begin
         data_word        = '0;
         data_word[7:0]   = rxf_data;
         data_word[9]     = rxf_frame_err;
         data_word[10]    = rxf_break;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_DATA: bus_rdata = data_word;
         SEL_LVL:  bus_rdata = {16'h0, 8'(txf_level), 8'(rxf_level)};
         SEL_STAT: bus_rdata = 32'(st_q);
         SEL_CTRL: bus_rdata = 32'(cfg_ctrl);
         SEL_RATE: bus_rdata = 32'(cfg_rate);
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = (st_q[ST_TXREQ] & cfg_ctrl[CB_TXEN])
              | ((st_q[ST_RXTRIG] | st_q[ST_RXTMO]) & cfg_ctrl[CB_RXEN])
              | ((st_q[ST_FRAME] | st_q[ST_BRK] | st_q[ST_OVR]) & cfg_ctrl[CB_ERREN]);
endmodule

// File: rtl/hsu_regfront_chk.sv
module hsu_regfront_chk #(
   parameter int LVL_W  = 8,
   parameter int CTRL_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       bus_wdata,
   input logic              stat_wr,
   input logic              ctrl_wr,
   input logic [6:0]        evt,
   input logic [6:0]        st_q,
   input logic [CTRL_W-1:0] cfg_ctrl,
   input logic              tx_break,
   input logic              irq,
   input logic              rxf_pop,
   input logic [LVL_W-1:0]  rxf_level
);
   logic unused_chk;
   assign unused_chk = ^{bus_wdata, evt, st_q, cfg_ctrl};

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[0] && !(stat_wr && bus_wdata[0]) |=> st_q[0]);

   // R5
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && bus_wdata[5] && !evt[5] |=> !st_q[5]);

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[3] |=> st_q[3]);

   // R2
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> rxf_level != '0);

   // R9
   brk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> tx_break == $past(bus_wdata[8]));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl[7:5] == 3'b000 |-> !irq);

   // R8
   irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[0] && cfg_ctrl[5] |-> irq);
endmodule

bind hsu_regfront hsu_regfront_chk #(.LVL_W(LVL_W), .CTRL_W(CTRL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wdata (bus_wdata),
   .stat_wr   (stat_wr),
   .ctrl_wr   (ctrl_wr),
   .evt       (evt),
   .st_q      (st_q),
   .cfg_ctrl  (cfg_ctrl),
   .tx_break  (tx_break),
   .irq       (irq),
   .rxf_pop   (rxf_pop),
   .rxf_level (rxf_level)
);

// File: tb/hsu_regfront_tb.sv
`timescale 1ns/1ps
module hsu_regfront_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  rxf_data = '0;
   logic        rxf_frame_err = 1'b0, rxf_break = 1'b0;
   logic [7:0]  rxf_level = '0;
   logic        rxf_pop;
   logic [7:0]  txf_level = '0;
   logic        txf_push;
   logic [7:0]  txf_byte;
   logic [6:0]  ev_p = '0, ev_l = '0;
   logic [6:0]  evt;
   logic [21:0] cfg_ctrl;
   logic [7:0]  cfg_rate;
   logic        tx_break, irq;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   assign evt = ev_p | ev_l;

   always #2.5 clk = ~clk;

   hsu_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxf_data(rxf_data), .rxf_frame_err(rxf_frame_err), .rxf_break(rxf_break),
      .rxf_level(rxf_level), .rxf_pop(rxf_pop), .txf_level(txf_level),
      .txf_push(txf_push), .txf_byte(txf_byte), .evt(evt),
      .cfg_ctrl(cfg_ctrl), .cfg_rate(cfg_rate), .tx_break(tx_break), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic pop);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata; pop = rxf_pop;
      @(posedge clk); #1 bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                            output logic push, output logic [7:0] pb);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1 push = txf_push; pb = txf_byte;
      @(posedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk); ev_p = m;
      @(posedge clk); #1 ev_p = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        p;
      logic [7:0]  pb;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 reset state
      bus_read(5'h08, d, p); chk("R10 status reset", d, 0);
      bus_read(5'h0C, d, p); chk("R10 ctrl reset", d, 0);
      bus_read(5'h10, d, p); chk("R10 rate reset", d, 32'hFF);
      #0 chk("R10 irq reset", {31'b0, irq}, 0);
      for (int a = 5; a < 8; a++) begin
         bus_read(5'(a * 4), d, p); chk("R10 unmapped read", d, 0);
      end

      // R1 level word, with byte-lane address bits ignored
      for (int t = 0; t < 256; t += 37) begin
         for (int r = 0; r < 256; r += 51) begin
            txf_level = 8'(t); rxf_level = 8'(r);
            bus_read(5'h04 | 5'((t + r) % 4), d, p);
            chk("R1 level word", d, {16'h0, 8'(t), 8'(r)});
         end
      end

      // R2 empty read
      rxf_level = 0; rxf_data = 8'hA5; rxf_frame_err = 1; rxf_break = 1;
      bus_read(5'h00, d, p);
      chk("R2 empty data word", d, 32'h100);
      chk("R2 empty no pop", {31'b0, p}, 0);

      // R2 exhaustive data/flag sweep
      rxf_level = 8'd3;
      for (int f = 0; f < 4; f++) begin
         for (int b = 0; b < 256; b++) begin
            rxf_data = 8'(b); rxf_frame_err = f[0]; rxf_break = f[1];
            bus_read(5'h00, d, p);
            chk("R2 data word", d, {21'b0, f[1], f[0], 1'b0, 8'(b)});
            chk("R2 pop", {31'b0, p}, 1);
         end
      end

      // R3 transmit push
      for (int b = 0; b < 256; b += 17) begin
         bus_write(5'h00, 32'hFFFF_FF00 | 32'(b), p, pb);
         chk("R3 push", {31'b0, p}, 1);
         chk("R3 byte", {24'b0, pb}, 32'(b));
      end
      bus_write(5'h10, 32'h33, p, pb); chk("R3 no push on rate write", {31'b0, p}, 0);

      // R9 control, rate, break
      bus_write(5'h0C, 32'h0000_0100, p, pb);
      bus_read(5'h0C, d, p); chk("R9 ctrl readback", d, 32'h100);
      #0 chk("R9 break out", {31'b0, tx_break}, 1);
      bus_write(5'h0C, 32'hFFFF_FFFF, p, pb);
      bus_read(5'h0C, d, p); chk("R9 ctrl width", d, 32'h3F_FFFF);
      bus_write(5'h0C, 32'h0, p, pb);
      #0 chk("R9 break off", {31'b0, tx_break}, 0);
      bus_read(5'h10, d, p); chk("R9 rate readback", d, 32'h33);
      chk("R9 rate port", {24'b0, cfg_rate}, 32'h33);

      // R4 sticky latch, R5 write-one-to-clear
      for (int i = 0; i < 7; i++) begin
         if (i == 1 || i == 2) continue;
         pulse(7'(1 << i));
         repeat (3) @(posedge clk);
         bus_read(5'h08, d, p); chk("R4 sticky held", d, 32'(1 << i));
         bus_write(5'h08, 32'h0, p, pb);
         bus_read(5'h08, d, p); chk("R5 zero write keeps", d, 32'(1 << i));
         bus_write(5'h08, 32'(1 << i), p, pb);
         bus_read(5'h08, d, p); chk("R5 clear", d, 0);
      end
      pulse(7'h79);
      bus_write(5'h08, 32'h08, p, pb);
      bus_read(5'h08, d, p); chk("R5 selective clear", d, 32'h71);
      bus_write(5'h08, 32'h7F, p, pb);

      // R6 set beats clear in the same cycle
      @(negedge clk);
      ev_p = 7'h08; bus_sel = 1; bus_wr = 1; bus_addr = 5'h08; bus_wdata = 32'h08;
      @(posedge clk); #1 ev_p = 0; bus_sel = 0; bus_wr = 0;
      bus_read(5'h08, d, p); chk("R6 set wins", d, 32'h08);
      bus_write(5'h08, 32'h7F, p, pb);

      // R7 level-following bits
      ev_l = 7'h06;
      bus_read(5'h08, d, p); chk("R7 follow set", d, 32'h06);
      bus_write(5'h08, 32'h06, p, pb);
      bus_read(5'h08, d, p); chk("R7 write ignored", d, 32'h06);
      ev_l = 7'h02;
      bus_read(5'h08, d, p); chk("R7 follow partial", d, 32'h02);
      ev_l = 0;
      bus_read(5'h08, d, p); chk("R7 follow clear", d, 0);

      // R8 exhaustive irq sweep
      for (int en = 0; en < 8; en++) begin
         bus_write(5'h0C, 32'(en << 5), p, pb);
         for (int s = 0; s < 128; s++) begin
            logic exp_irq;
            ev_l = 7'(s) & 7'h06;
            pulse(7'(s) & 7'h79);
            exp_irq = (s[0] & en[0]) | ((s[1] | s[2]) & en[1])
                    | ((s[3] | s[4] | s[5]) & en[2]);
            @(negedge clk); #1
            chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq});
            ev_l = 0;
            bus_write(5'h08, 32'h7F, p, pb);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule